// File: doc/BRIEF.md
# Transfer Status and Error Flag Unit

This block keeps the flag state of a serial controller: which transfer-side events have happened, which FIFO conditions hold right now, and which error conditions have been seen. Single-cycle event pulses from the FIFOs and the shift engine set sticky flags. The live FIFO conditions pass straight through to the status view. Software reads a flag view and writes the same value back to acknowledge it. Every bit written as one is cleared, and every bit written as zero keeps its value.

Three enable registers pick which flags may drive the single active-high, level-sensitive interrupt line:
- one for the controller error class,
- one for the serial error class,
- one mask for the service and done flags.

All of them reset to zero, so the line stays low until software enables at least one source. The line stays high for as long as an enabled flag is set.

Top module: `xfer_flag_unit`

## Requirements
- R1: While `rst_n` is low, every flag, enable and mask output and `irq` read zero.
- R2: Bit positions in `op_flags` are fixed. A pulse on `ev_op[3]` (input done) sets bit 11, `ev_op[2]` (output done) sets bit 10, `ev_op[1]` (input service) sets bit 9 and `ev_op[0]` (output service) sets bit 8. Each bit stays set until it is cleared.
- R3: `op_flags` bits 7, 6, 5 and 4 follow `live_st[3:0]` (input full, output full, input not empty, output not empty) in the same cycle. Writes have no effect on them. Bits 3..0 and bits above 11 read zero.
- R4: A pulse on `ev_ctl_err[3:0]` (output overrun, input underrun, output underrun, input overrun) sets `ctl_err` bits 5..2 in that order. A set bit stays set until it is cleared.
- R5: A pulse on `ev_ser_err[1]` (clock overrun) sets `ser_err` bit 1, and a pulse on `ev_ser_err[0]` (clock underrun) sets bit 0. A set bit stays set until it is cleared.
- R6: The value of `wr_sel` chooses the target of a write (`wr_en` high): 0 is the status flags, 2 is the controller errors and 4 is the serial errors. Such a write clears, at the next clock edge, exactly the sticky bits written as one at their positions from R2, R4 and R5. All other bits keep their value.
- R7: If an event sets a sticky bit in the same cycle as a write that clears it, the bit ends up set.
- R8: `irq` is high whenever any of these bits is set, and low otherwise:
  - a `ctl_err` bit whose `ctl_en` bit is set,
  - a `ser_err` bit whose `ser_en` bit is set,
  - a sticky status bit whose `op_mask` bit is set.
- R9: A disabled error flag still records its event but does not raise `irq`.
- R10: After reset, `op_mask` is zero, so the service and done flags do not raise `irq`.
- R11: A write with `wr_sel` equal to 1 loads `op_mask` bits 11..8, a value of 3 loads `ctl_en` bits 5..2, and a value of 5 loads `ser_en` bits 1..0. The new value can be read at the next clock edge. Other bit positions read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | REG_W | Write data |
| ev_op | input | 4 | Done and service event pulses |
| live_st | input | 4 | Live FIFO full and not-empty conditions |
| ev_ctl_err | input | 4 | Controller error event pulses |
| ev_ser_err | input | 2 | Serial error event pulses |
| op_flags | output | REG_W | Status flag view |
| op_mask | output | REG_W | Status interrupt mask |
| ctl_err | output | REG_W | Controller error flags |
| ctl_en | output | REG_W | Controller error enables |
| ser_err | output | REG_W | Serial error flags |
| ser_en | output | REG_W | Serial error enables |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench targets an event that arrives in the same cycle as the write clearing its bit. A design that gives the clear priority would lose that event, and the interrupt would never fire for it. A write-back of zeros and a write-back with bits set only at the live positions are both checked: a design that clears on any write, or that latches the live FIFO bits, would drop flags or freeze stale status. The bench also checks that a flag is still recorded while its enable is off, and that setting the enable later raises the interrupt at once. A design that gated the recording instead of the interrupt would miss those flags.

// File: rtl/flag_pkg.sv
package flag_pkg;
  typedef enum logic [2:0] {
    SEL_OP      = 3'd0,
    SEL_OP_MASK = 3'd1,
    SEL_CTL_ERR = 3'd2,
    SEL_CTL_EN  = 3'd3,
    SEL_SER_ERR = 3'd4,
    SEL_SER_EN  = 3'd5
  } reg_sel_e;

  localparam int N_OP      = 4;
  localparam int N_LIVE    = 4;
  localparam int N_CTL     = 4;
  localparam int N_SER     = 2;
  localparam int OP_LSB    = 8;
  localparam int LIVE_LSB  = 4;
  localparam int CTL_LSB   = 2;
  localparam int SER_LSB   = 0;
endpackage

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] q_o
);
  function automatic logic [N-1:0] next_flags(input logic [N-1:0] cur,
                                              input logic [N-1:0] set,
                                              input logic         clr_en,
                                              input logic [N-1:0] clr);
    logic [N-1:0] kill;
    kill = clr_en ? clr : '0;
    return (cur & ~kill) | set;
  endfunction

  logic [N-1:0] q_d;
  assign q_d = next_flags(q_o, set_i, clr_en_i, clr_mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/en_reg.sv
module en_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int NO = 4,
  parameter int NC = 4,
  parameter int NS = 2
) (
  input  logic [NO-1:0] op_i,
  input  logic [NO-1:0] op_mask_i,
  input  logic [NC-1:0] ctl_i,
  input  logic [NC-1:0] ctl_en_i,
  input  logic [NS-1:0] ser_i,
  input  logic [NS-1:0] ser_en_i,
  output logic          irq_o
);
  function automatic logic any_hit(input logic [31:0] f, input logic [31:0] e);
    return |(f & e);
  endfunction

  logic hit_op, hit_ctl, hit_ser;
  assign hit_op  = any_hit(32'(op_i),  32'(op_mask_i));
  assign hit_ctl = any_hit(32'(ctl_i), 32'(ctl_en_i));
  assign hit_ser = any_hit(32'(ser_i), 32'(ser_en_i));
  assign irq_o   = hit_op | hit_ctl | hit_ser;
endmodule

// File: rtl/xfer_flag_unit.sv
module xfer_flag_unit
  import flag_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_sel,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [N_OP-1:0]      ev_op,
  input  logic [N_LIVE-1:0]    live_st,
  input  logic [N_CTL-1:0]     ev_ctl_err,
  input  logic [N_SER-1:0]     ev_ser_err,
  output logic [REG_W-1:0]     op_flags,
  output logic [REG_W-1:0]     op_mask,
  output logic [REG_W-1:0]     ctl_err,
  output logic [REG_W-1:0]     ctl_en,
  output logic [REG_W-1:0]     ser_err,
  output logic [REG_W-1:0]     ser_en,
  output logic                 irq
);
  localparam int OP_MSB  = OP_LSB + N_OP - 1;
  localparam int LV_MSB  = LIVE_LSB + N_LIVE - 1;
  localparam int CTL_MSB = CTL_LSB + N_CTL - 1;
  localparam int SER_MSB = SER_LSB + N_SER - 1;

  // named write strobes
  logic wr_op_clr, wr_ctl_clr, wr_ser_clr;
  logic wr_op_mask, wr_ctl_en, wr_ser_en;
  assign wr_op_clr  = wr_en && (wr_sel == SEL_OP);
  assign wr_ctl_clr = wr_en && (wr_sel == SEL_CTL_ERR);
  assign wr_ser_clr = wr_en && (wr_sel == SEL_SER_ERR);
  assign wr_op_mask = wr_en && (wr_sel == SEL_OP_MASK);
  assign wr_ctl_en  = wr_en && (wr_sel == SEL_CTL_EN);
  assign wr_ser_en  = wr_en && (wr_sel == SEL_SER_EN);

  logic [N_OP-1:0]  op_q,  op_mask_q;
  logic [N_CTL-1:0] ctl_q, ctl_en_q;
  logic [N_SER-1:0] ser_q, ser_en_q;

  sticky_bank #(.N(N_OP)) u_op_flags (
    .clk(clk), .rst_n(rst_n), .set_i(ev_op), .clr_en_i(wr_op_clr),
    .clr_mask_i(wr_data[OP_MSB:OP_LSB]), .q_o(op_q));
  sticky_bank #(.N(N_CTL)) u_ctl_flags (
    .clk(clk), .rst_n(rst_n), .set_i(ev_ctl_err), .clr_en_i(wr_ctl_clr),
    .clr_mask_i(wr_data[CTL_MSB:CTL_LSB]), .q_o(ctl_q));
  sticky_bank #(.N(N_SER)) u_ser_flags (
    .clk(clk), .rst_n(rst_n), .set_i(ev_ser_err), .clr_en_i(wr_ser_clr),
    .clr_mask_i(wr_data[SER_MSB:SER_LSB]), .q_o(ser_q));

  en_reg #(.N(N_OP)) u_op_mask (
    .clk(clk), .rst_n(rst_n), .ld_i(wr_op_mask),
    .d_i(wr_data[OP_MSB:OP_LSB]), .q_o(op_mask_q));
  en_reg #(.N(N_CTL)) u_ctl_en (
    .clk(clk), .rst_n(rst_n), .ld_i(wr_ctl_en),
    .d_i(wr_data[CTL_MSB:CTL_LSB]), .q_o(ctl_en_q));
  en_reg #(.N(N_SER)) u_ser_en (
    .clk(clk), .rst_n(rst_n), .ld_i(wr_ser_en),
    .d_i(wr_data[SER_MSB:SER_LSB]), .q_o(ser_en_q));

  irq_merge #(.NO(N_OP), .NC(N_CTL), .NS(N_SER)) u_irq (
    .op_i(op_q), .op_mask_i(op_mask_q), .ctl_i(ctl_q), .ctl_en_i(ctl_en_q),
    .ser_i(ser_q), .ser_en_i(ser_en_q), .irq_o(irq));

  always_comb begin
    op_flags = '0;
    op_flags[OP_MSB:OP_LSB]  = op_q;
    op_flags[LV_MSB:LIVE_LSB] = live_st;
    op_mask = '0;
    op_mask[OP_MSB:OP_LSB] = op_mask_q;
    ctl_err = '0;
    ctl_err[CTL_MSB:CTL_LSB] = ctl_q;
    ctl_en = '0;
    ctl_en[CTL_MSB:CTL_LSB] = ctl_en_q;
    ser_err = '0;
    ser_err[SER_MSB:SER_LSB] = ser_q;
    ser_en = '0;
    ser_en[SER_MSB:SER_LSB] = ser_en_q;
  end
endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk
  import flag_pkg::*;
#(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_sel,
  input logic [REG_W-1:0] wr_data,
  input logic [3:0]       live_st,
  input logic [3:0]       ev_ctl_err,
  input logic [1:0]       ev_ser_err,
  input logic [REG_W-1:0] op_flags,
  input logic [REG_W-1:0] op_mask,
  input logic [REG_W-1:0] ctl_err,
  input logic [REG_W-1:0] ctl_en,
  input logic [REG_W-1:0] ser_err,
  input logic [REG_W-1:0] ser_en,
  input logic             irq
);
  assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_CTL_ERR) |=> ((ctl_err & $past(ctl_err)) == $past(ctl_err)));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ctl_err != 4'd0) |=> ((ctl_err[5:2] & $past(ev_ctl_err)) == $past(ev_ctl_err)));

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_SER_ERR && ev_ser_err == 2'd0)
      |=> (ser_err[1:0] == ($past(ser_err[1:0]) & ~$past(wr_data[1:0]))));

  assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en == '0 && ser_en == '0 && op_mask == '0) |-> !irq);

  assert_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (op_flags[7:4] == live_st && op_flags[3:0] == 4'd0));
endmodule

bind xfer_flag_unit flag_unit_chk #(.REG_W(REG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .live_st(live_st), .ev_ctl_err(ev_ctl_err), .ev_ser_err(ev_ser_err),
  .op_flags(op_flags), .op_mask(op_mask), .ctl_err(ctl_err), .ctl_en(ctl_en),
  .ser_err(ser_err), .ser_en(ser_en), .irq(irq));

// File: tb/xfer_flag_unit_tb.sv
module xfer_flag_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [3:0] ev_op = '0, live_st = '0, ev_ctl_err = '0;
  logic [1:0] ev_ser_err = '0;
  logic [W-1:0] op_flags, op_mask, ctl_err, ctl_en, ser_err, ser_en;
  logic irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_flag_unit #(.REG_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ev_op(ev_op), .live_st(live_st), .ev_ctl_err(ev_ctl_err), .ev_ser_err(ev_ser_err),
    .op_flags(op_flags), .op_mask(op_mask), .ctl_err(ctl_err), .ctl_en(ctl_en),
    .ser_err(ser_err), .ser_en(ser_en), .irq(irq));

  // reference state, kept in the bench's own terms
  logic [3:0] m_op = '0, m_mask = '0, m_ctl = '0, m_cen = '0;
  logic [1:0] m_ser = '0, m_sen = '0;

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_all(input string req);
    logic exp_irq;
    exp_irq = (|(m_ctl & m_cen)) || (|(m_ser & m_sen)) || (|(m_op & m_mask));
    chk({req, " op R2"},   op_flags, {4'h0, m_op, live_st, 4'h0});
    chk({req, " ctl R4"},  ctl_err,  {10'h0, m_ctl, 2'b00});
    chk({req, " ser R5"},  ser_err,  {14'h0, m_ser});
    chk({req, " en R11"},  {op_mask[11:8], ctl_en[5:2], 6'h0, ser_en[1:0]},
                           {m_mask, m_cen, 6'h0, m_sen});
    chk({req, " irq R8"},  {15'h0, irq}, {15'h0, exp_irq});
  endtask

  // one cycle: drive at negedge, model the edge, sample at next negedge
  task automatic step(input logic [3:0] op, input logic [3:0] ce, input logic [1:0] se,
                      input logic we, input logic [2:0] sel, input logic [W-1:0] d,
                      input logic [3:0] lv, input string req);
    ev_op = op; ev_ctl_err = ce; ev_ser_err = se;
    wr_en = we; wr_sel = sel; wr_data = d; live_st = lv;
    if (we && sel == 3'd0) m_op  = m_op  & ~d[11:8];
    if (we && sel == 3'd2) m_ctl = m_ctl & ~d[5:2];
    if (we && sel == 3'd4) m_ser = m_ser & ~d[1:0];
    if (we && sel == 3'd1) m_mask = d[11:8];
    if (we && sel == 3'd3) m_cen  = d[5:2];
    if (we && sel == 3'd5) m_sen  = d[1:0];
    m_op = m_op | op; m_ctl = m_ctl | ce; m_ser = m_ser | se;
    @(negedge clk);
    chk_all(req);
    ev_op = '0; ev_ctl_err = '0; ev_ser_err = '0; wr_en = 1'b0;
  endtask

  // vector: op[29:26] ctl[25:22] ser[21:20] we[19] sel[18:16] data[15:0]
  localparam logic [29:0] VEC [12] = '{
    {4'h0, 4'h8, 2'd0, 1'b0, 3'd0, 16'h0000},  // R4 disabled error, R9
    {4'h0, 4'h0, 2'd0, 1'b1, 3'd3, 16'h003C},  // R11 enable ctl, R8
    {4'h0, 4'h0, 2'd1, 1'b0, 3'd0, 16'h0000},  // R5 clock underrun
    {4'h0, 4'h0, 2'd0, 1'b1, 3'd2, 16'h0020},  // R6 clear ctl bit 5
    {4'hF, 4'h0, 2'd0, 1'b0, 3'd0, 16'h0000},  // R2 all status events
    {4'h0, 4'h0, 2'd0, 1'b1, 3'd1, 16'h0100},  // R11 mask out service
    {4'h1, 4'h0, 2'd0, 1'b1, 3'd0, 16'h0100},  // R7 set beats clear
    {4'h0, 4'h0, 2'd0, 1'b1, 3'd0, 16'h0F00},  // R6 clear all status
    {4'h0, 4'h0, 2'd0, 1'b1, 3'd5, 16'h0003},  // R11 serial enables
    {4'h0, 4'h0, 2'd0, 1'b1, 3'd4, 16'h0000},  // R6 zeros keep bits
    {4'h0, 4'h0, 2'd2, 1'b1, 3'd4, 16'h0001},  // R6 R7 mixed
    {4'h0, 4'h6, 2'd0, 1'b1, 3'd0, 16'h00F0}   // R3 live write ignored
  };

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, with stimulus pending
    ev_op = 4'hF; ev_ctl_err = 4'hF; ev_ser_err = 2'h3;
    @(negedge clk); @(negedge clk);
    chk("R1 op", op_flags, 16'h0);
    chk("R1 ctl", ctl_err | ctl_en, 16'h0);
    chk("R1 ser", ser_err | ser_en | op_mask, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    ev_op = '0; ev_ctl_err = '0; ev_ser_err = '0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][29:26], VEC[i][25:22], VEC[i][21:20], VEC[i][19],
           VEC[i][18:16], VEC[i][15:0], 4'(i), $sformatf("vec%0d", i));
    end

    // R3: live bits follow input with no clock edge
    live_st = 4'b1010; #1;
    chk("R3 live follow", op_flags[7:4], 4'b1010);

    // R10: after a fresh reset, status events raise no interrupt
    rst_n = 1'b0; @(negedge clk);
    m_op = '0; m_mask = '0; m_ctl = '0; m_cen = '0; m_ser = '0; m_sen = '0;
    chk("R1 reset again", ctl_err | ser_err | op_mask, 16'h0);
    rst_n = 1'b1; @(negedge clk);
    step(4'hF, 4'h0, 2'd0, 1'b0, 3'd0, 16'h0, 4'h0, "R10 mask zero");
    chk("R10 irq low", {15'h0, irq}, 16'h0);
    // R9 then late enable raises irq immediately
    step(4'h0, 4'h1, 2'd0, 1'b0, 3'd0, 16'h0, 4'h0, "R9 recorded");
    chk("R9 irq low", {15'h0, irq}, 16'h0);
    step(4'h0, 4'h0, 2'd0, 1'b1, 3'd3, 16'h0004, 4'h0, "R9 late enable");
    chk("R8 irq high", {15'h0, irq}, 16'h1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule